// File: doc/BRIEF.md
# Multi-lane deskew and word aligner

This block sits behind the bit samplers of a 16-bit source-synchronous packet interface. It receives one sample per clock from each data lane and one from the control-flag lane. It rebuilds whole words from these samples, even when the lanes reach it with different delays. Each lane's delay is measured during training. A training run begins when every lane shows the training control word. The orthogonal data word that follows makes every lane change value once, and the clock count at which each lane changes gives its skew.

The measured delays become per-lane offsets. Each lane is then read from a tap of its own short delay line, so that every bit of an output word comes from the same transmitted word. A confirmation option applies a new result only when two runs in a row agree. A diagnostic flag reports lane spreads of more than two bits, and it clears itself on the next run that is in range. A processor can override the measured offsets with fixed per-lane phases.

Top module: `dsk_aligner`

## Requirements
- R1: After reset, `aligned_valid`, `skew_oor`, `lane_offsets`, `word_out` and `ctl_out` are all zero.
- R2: A training run is armed only while `if_en` is 1 and every lane's current sample equals the training value. That value is 1 on the control lane and bit i of 0x0FFF on data lane i.
- R3: In a run, the offset of each lane is the clock at which it first departs from its training value, minus the clock of the earliest lane. Lane k reports its offset in `lane_offsets[2k+1:2k]`, with the control lane at k = 16.
- R4: Once offsets are applied, each output word carries the bits of one transmitted word on all 17 lanes, at a fixed latency of 1 + MAX_OFF + (the smallest lane delay) clocks.
- R5: With `cfg_confirm` = 1, a run's offsets are applied only if the previous completed in-range run gave identical offsets. With `cfg_confirm` = 0, every in-range run is applied. Applying a run sets `aligned_valid`.
- R6: After each completed run, `skew_oor` becomes 1 if the latest lane minus the earliest lane is more than 2 clocks, and 0 otherwise.
- R7: A run whose spread exceeds MAX_OFF (3) does not change `lane_offsets` or `aligned_valid`. It also breaks the chain of confirming runs.
- R8: While `cfg_force` = 1, each lane uses its 2-bit field of `cfg_phase` (lane k at bits [2k+1:2k]) as its offset, in place of the measured one. `lane_offsets` keeps showing the measured value.
- R9: While `if_en` is 0, `aligned_valid` is 0 from the next clock, no run is armed, and the confirmation history is cleared. After re-enabling, `aligned_valid` stays 0 until a run is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_en | input | 1 | Interface enable |
| cfg_confirm | input | 1 | Require two matching runs before applying |
| cfg_force | input | 1 | Use processor phases instead of measured offsets |
| cfg_phase | input | 34 | Per-lane forced phase, 2 bits per lane |
| lane_data | input | 16 | One sample per data lane |
| lane_ctl | input | 1 | Sample of the control-flag lane |
| word_out | output | 16 | Aligned data word |
| ctl_out | output | 1 | Aligned control flag (1 = control word) |
| aligned_valid | output | 1 | Offsets from a successful run are in use |
| skew_oor | output | 1 | Last completed run had a spread above 2 |
| lane_offsets | output | 34 | Applied per-lane offsets, 2 bits per lane |

## Verification
The bench builds the block with its defaults: 16 data lanes, MAX_OFF = 3, OOR_LIMIT = 2, a 32-clock window and the confirmation hardware present. With these values a spread of exactly 3 can be reached that raises the range flag while still being applied, and a spread of 5 falls outside what the delay lines can correct. Random lane delays of 0 to 3 and random forced phases are mixed with directed delay patterns. These exercise runs that match, runs that differ and runs that are out of range, in both confirmation modes.

// File: rtl/dsk_pkg.sv
`timescale 1ns/1ps
package dsk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEAS = 2'd1,
      ST_EVAL = 2'd2
   } dsk_state_e;
endpackage

// File: rtl/dsk_lane.sv
`timescale 1ns/1ps
// One lane: sample delay line, tap select for alignment, first-departure stamp.
module dsk_lane #(
   parameter int MAX_OFF = 3,
   parameter int OW      = 2,
   parameter int CW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          samp_i,
   input  logic          ref_i,
   input  logic          arm_i,
   input  logic          meas_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [OW-1:0] tap_i,
   output logic          raw_o,
   output logic          seen_o,
   output logic [CW-1:0] stamp_o,
   output logic          algn_o
);
   logic [MAX_OFF:0] sr;
   logic             pick;

   always_ff @(posedge clk) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[MAX_OFF-1:0], samp_i};
   end

   assign raw_o = sr[0];

   // larger offset means the lane arrived later, so it needs a shorter delay
   always_comb begin
      pick = sr[MAX_OFF];
      for (int k = 0; k <= MAX_OFF; k++) begin
         if (tap_i == OW'(k)) pick = sr[MAX_OFF-k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) algn_o <= 1'b0;
      else        algn_o <= pick;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_o  <= 1'b0;
         stamp_o <= '0;
      end else if (arm_i) begin
         seen_o  <= 1'b0;
      end else if (meas_i && !seen_o && (sr[0] != ref_i)) begin
         seen_o  <= 1'b1;
         stamp_o <= cnt_i;
      end
   end

   // R3
   seen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_o && !arm_i) |=> seen_o);
endmodule

// File: rtl/dsk_skew_eval.sv
`timescale 1ns/1ps
// Reduces per-lane stamps to a spread, range flags and candidate offsets.
module dsk_skew_eval #(
   parameter int NL        = 17,
   parameter int CW        = 5,
   parameter int OW        = 2,
   parameter int MAX_OFF   = 3,
   parameter int OOR_LIMIT = 2
) (
   input  logic [NL*CW-1:0] stamps_i,
   input  logic [NL-1:0]    seen_i,
   output logic             all_seen_o,
   output logic             in_range_o,
   output logic             oor_o,
   output logic [NL*OW-1:0] cand_o
);
   logic [CW-1:0] mn, mx, spread;

   always_comb begin
      mn = '1;
      mx = '0;
      for (int i = 0; i < NL; i++) begin
         if (stamps_i[i*CW +: CW] < mn) mn = stamps_i[i*CW +: CW];
         if (stamps_i[i*CW +: CW] > mx) mx = stamps_i[i*CW +: CW];
      end
   end

   assign spread     = mx - mn;
   assign all_seen_o = &seen_i;
   assign in_range_o = (spread <= CW'(MAX_OFF));
   assign oor_o      = (spread >  CW'(OOR_LIMIT));

   always_comb begin
      for (int i = 0; i < NL; i++) begin
         cand_o[i*OW +: OW] = OW'(stamps_i[i*CW +: CW] - mn);
      end
   end
endmodule

// File: rtl/dsk_ctrl.sv
`timescale 1ns/1ps
// Run sequencing, optional confirmation, applied offsets and flags.
module dsk_ctrl
   import dsk_pkg::*;
#(
   parameter int NL         = 17,
   parameter int OW         = 2,
   parameter int CW         = 5,
   parameter int WIN        = 32,
   parameter bit CONFIRM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             if_en,
   input  logic             cfg_confirm,
   input  logic             train_hit,
   input  logic             all_seen,
   input  logic             in_range,
   input  logic             oor_now,
   input  logic [NL*OW-1:0] cand,
   output logic             arm,
   output logic             meas,
   output logic [CW-1:0]    cnt,
   output logic [NL*OW-1:0] off_q,
   output logic             valid_q,
   output logic             oor_q
);
   dsk_state_e st;
   logic       accept;

   assign arm  = if_en && (st == ST_IDLE) && train_hit;
   assign meas = (st == ST_MEAS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         off_q   <= '0;
         valid_q <= 1'b0;
         oor_q   <= 1'b0;
      end else if (!if_en) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         valid_q <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (arm) begin
                  st  <= ST_MEAS;
                  cnt <= '0;
               end
            end
            ST_MEAS: begin
               if (cnt == CW'(WIN-1)) st <= ST_EVAL;
               else                   cnt <= cnt + 1'b1;
            end
            ST_EVAL: begin
               st <= ST_IDLE;
               if (all_seen) begin
                  oor_q <= oor_now;
                  if (in_range && accept) begin
                     off_q   <= cand;
                     valid_q <= 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   generate
      if (CONFIRM_EN) begin : g_confirm
         logic [NL*OW-1:0] prev_q;
         logic             prev_v;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q <= '0;
               prev_v <= 1'b0;
            end else if (!if_en) begin
               prev_v <= 1'b0;
            end else if (st == ST_EVAL && all_seen) begin
               if (in_range) begin
                  prev_q <= cand;
                  prev_v <= 1'b1;
               end else begin
                  prev_v <= 1'b0;
               end
            end
         end

         assign accept = !cfg_confirm || (prev_v && (prev_q == cand));

         // R5
         confirm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (if_en && st == ST_EVAL && cfg_confirm && !prev_v)
            |=> ($stable(off_q) && $stable(valid_q)));
      end else begin : g_single
         logic unused_confirm;
         assign unused_confirm = cfg_confirm;
         assign accept = 1'b1;
      end
   endgenerate

   // R9
   en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !if_en |=> !valid_q);
   // R5
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(st == ST_EVAL));
   // R3
   off_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_q != $past(off_q)) |-> $past(st == ST_EVAL));
   // R6
   oor_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oor_q != $past(oor_q)) |-> $past(st == ST_EVAL));
   // R2
   meas_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(meas) |-> $past(train_hit && if_en));
endmodule

// File: rtl/dsk_aligner.sv
`timescale 1ns/1ps
// Top: lane array, skew evaluation and run controller.
module dsk_aligner #(
   parameter int          DATA_W     = 16,
   parameter int          MAX_OFF    = 3,
   parameter int          OOR_LIMIT  = 2,
   parameter int          WIN        = 32,
   parameter logic [15:0] TRAIN_WORD = 16'h0FFF,
   parameter bit          CONFIRM_EN = 1'b1,
   localparam int         NL         = DATA_W + 1,
   localparam int         OW         = $clog2(MAX_OFF + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             if_en,
   input  logic             cfg_confirm,
   input  logic             cfg_force,
   input  logic [NL*OW-1:0] cfg_phase,
   input  logic [DATA_W-1:0] lane_data,
   input  logic             lane_ctl,
   output logic [DATA_W-1:0] word_out,
   output logic             ctl_out,
   output logic             aligned_valid,
   output logic             skew_oor,
   output logic [NL*OW-1:0] lane_offsets
);
   localparam int CW = $clog2(WIN);

   if (MAX_OFF < 1)            begin : g_bad_off   $error("MAX_OFF must be at least 1"); end
   if (OOR_LIMIT > MAX_OFF)    begin : g_bad_oor   $error("OOR_LIMIT above MAX_OFF"); end
   if (WIN <= 2 * MAX_OFF + 2) begin : g_bad_win   $error("WIN too short for MAX_OFF"); end
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_w  $error("DATA_W out of range"); end

   logic [NL-1:0]    samp, refv, raw, seen, algn;
   logic [NL*CW-1:0] stamps;
   logic [NL*OW-1:0] cand, off_q;
   logic [CW-1:0]    cnt;
   logic             arm, meas, all_seen, in_range, oor_now, train_hit;

   assign samp      = {lane_ctl, lane_data};
   assign refv      = {1'b1, TRAIN_WORD[DATA_W-1:0]};
   assign train_hit = (raw == refv);

   generate
      for (genvar i = 0; i < NL; i++) begin : g_lane
         logic [OW-1:0] tap;
         assign tap = cfg_force ? cfg_phase[i*OW +: OW] : off_q[i*OW +: OW];

         dsk_lane #(.MAX_OFF(MAX_OFF), .OW(OW), .CW(CW)) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .samp_i (samp[i]),
            .ref_i  (refv[i]),
            .arm_i  (arm),
            .meas_i (meas),
            .cnt_i  (cnt),
            .tap_i  (tap),
            .raw_o  (raw[i]),
            .seen_o (seen[i]),
            .stamp_o(stamps[i*CW +: CW]),
            .algn_o (algn[i])
         );
      end
   endgenerate

   dsk_skew_eval #(
      .NL(NL), .CW(CW), .OW(OW), .MAX_OFF(MAX_OFF), .OOR_LIMIT(OOR_LIMIT)
   ) eval_i (
      .stamps_i  (stamps),
      .seen_i    (seen),
      .all_seen_o(all_seen),
      .in_range_o(in_range),
      .oor_o     (oor_now),
      .cand_o    (cand)
   );

   dsk_ctrl #(
      .NL(NL), .OW(OW), .CW(CW), .WIN(WIN), .CONFIRM_EN(CONFIRM_EN)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .if_en      (if_en),
      .cfg_confirm(cfg_confirm),
      .train_hit  (train_hit),
      .all_seen   (all_seen),
      .in_range   (in_range),
      .oor_now    (oor_now),
      .cand       (cand),
      .arm        (arm),
      .meas       (meas),
      .cnt        (cnt),
      .off_q      (off_q),
      .valid_q    (aligned_valid),
      .oor_q      (skew_oor)
   );

   assign word_out     = algn[DATA_W-1:0];
   assign ctl_out      = algn[DATA_W];
   assign lane_offsets = off_q;
endmodule

// File: tb/dsk_aligner_tb.sv
`timescale 1ns/1ps
module dsk_aligner_tb_top;
   localparam int NL   = 17;
   localparam int MAXO = 3;
   localparam int HMAX = 16384;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        if_en = 1'b0;
   logic        cfg_confirm = 1'b0;
   logic        cfg_force = 1'b0;
   logic [33:0] cfg_phase = '0;
   logic [15:0] lane_data = '0;
   logic        lane_ctl = 1'b0;
   logic [15:0] word_out;
   logic        ctl_out, aligned_valid, skew_oor;
   logic [33:0] lane_offsets;

   always #2 clk = ~clk;

   dsk_aligner dut_i (
      .clk(clk), .rst_n(rst_n), .if_en(if_en), .cfg_confirm(cfg_confirm),
      .cfg_force(cfg_force), .cfg_phase(cfg_phase), .lane_data(lane_data),
      .lane_ctl(lane_ctl), .word_out(word_out), .ctl_out(ctl_out),
      .aligned_valid(aligned_valid), .skew_oor(skew_oor), .lane_offsets(lane_offsets)
   );

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;
   logic [16:0] hist [0:HMAX-1];
   int d [NL];
   int exp_off [NL];
   logic [33:0] prev_m = '0;
   bit pv_m = 0, val_m = 0, oor_m = 0, en_m = 0, conf_m = 0, force_m = 0, chk_on = 0;
   string data_tag = "R4";

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [33:0] exp_pack();
      logic [33:0] v;
      for (int i = 0; i < NL; i++) v[i*2 +: 2] = exp_off[i][1:0];
      return v;
   endfunction

   function automatic logic [16:0] rnd_word();
      logic [16:0] w;
      w = 17'($urandom);
      if (w == 17'h10FFF) w = 17'h10FFE;
      return w;
   endfunction

   task automatic check_data();
      logic [16:0] expv, got;
      bit ok_all;
      int k;
      ok_all = 1;
      k = cyc - 1;
      for (int i = 0; i < NL; i++) begin
         int eff, src;
         eff = force_m ? int'(cfg_phase[i*2 +: 2]) : exp_off[i];
         src = k - 1 - MAXO + eff - d[i];
         if (src < 0) ok_all = 0;
         else expv[i] = hist[src][i];
      end
      got = {ctl_out, word_out};
      if (ok_all) chk(got == expv, data_tag, 64'(got), 64'(expv));
   endtask

   task automatic send(input logic [16:0] w);
      logic [16:0] drv;
      @(negedge clk);
      if (chk_on) check_data();
      hist[cyc] = w;
      for (int i = 0; i < NL; i++) begin
         int s;
         s = cyc - d[i];
         drv[i] = (s >= 0) ? hist[s][i] : 1'b0;
      end
      lane_data = drv[15:0];
      lane_ctl  = drv[16];
      cyc++;
   endtask

   // model of one completed in-window run
   task automatic model_run();
      int mn, mx;
      logic [33:0] cand;
      if (!en_m) return;
      mn = 99; mx = -1;
      for (int i = 0; i < NL; i++) begin
         if (d[i] < mn) mn = d[i];
         if (d[i] > mx) mx = d[i];
      end
      oor_m = (mx - mn) > 2;
      if ((mx - mn) <= MAXO) begin
         for (int i = 0; i < NL; i++) cand[i*2 +: 2] = 2'(d[i] - mn);
         if (!conf_m || (pv_m && cand == prev_m)) begin
            for (int i = 0; i < NL; i++) exp_off[i] = d[i] - mn;
            val_m = 1;
         end
         prev_m = cand;
         pv_m = 1;
      end else begin
         pv_m = 0;
      end
   endtask

   task automatic burst();
      repeat (8)  send(17'h00000);
      repeat (10) send(17'h10FFF);
      repeat (10) send(17'h0F000);
      repeat (45) send(rnd_word());
      model_run();
   endtask

   task automatic after_checks(input string tag);
      chk(lane_offsets == exp_pack(), tag, 64'(lane_offsets), 64'(exp_pack()));
      chk(aligned_valid == val_m, tag, 64'(aligned_valid), 64'(val_m));
      chk(skew_oor == oor_m, "R6", 64'(skew_oor), 64'(oor_m));
   endtask

   task automatic data_run(input int n);
      if (!val_m && !force_m) return;
      chk_on = 1;
      repeat (n) send(rnd_word());
      chk_on = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NL; i++) begin d[i] = 0; exp_off[i] = 0; end
      repeat (4) send(17'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(aligned_valid == 1'b0, "R1", 64'(aligned_valid), 0);
      chk(skew_oor == 1'b0, "R1", 64'(skew_oor), 0);
      chk(lane_offsets == '0, "R1", 64'(lane_offsets), 0);
      chk({ctl_out, word_out} == '0, "R1", 64'({ctl_out, word_out}), 0);

      if_en = 1; en_m = 1;
      // R2: training value absent while enabled - nothing armed
      repeat (40) send(rnd_word());
      chk(aligned_valid == 1'b0, "R2", 64'(aligned_valid), 0);

      // R3 R4: spread 2
      for (int i = 0; i < NL; i++) d[i] = i % 3;
      burst(); after_checks("R3"); data_run(30);
      // R6: spread 3, flagged but applied
      for (int i = 0; i < NL; i++) d[i] = i % 4;
      burst(); after_checks("R6"); data_run(30);
      // R6: back in range clears
      for (int i = 0; i < NL; i++) d[i] = (i % 2) + 1;
      burst(); after_checks("R6"); data_run(30);
      // R7: spread 5 not applied
      for (int i = 0; i < NL; i++) d[i] = (i == 5) ? 5 : 0;
      burst(); after_checks("R7");

      // R9 disable
      if_en = 0; en_m = 0; val_m = 0; pv_m = 0;
      repeat (2) send(rnd_word());
      chk(aligned_valid == 1'b0, "R9", 64'(aligned_valid), 0);
      for (int i = 0; i < NL; i++) d[i] = 3 - (i % 4);
      burst(); after_checks("R9");
      if_en = 1; en_m = 1;
      repeat (20) send(rnd_word());
      chk(aligned_valid == 1'b0, "R9", 64'(aligned_valid), 0);

      // R5 confirmation
      cfg_confirm = 1; conf_m = 1;
      for (int i = 0; i < NL; i++) d[i] = i % 3;
      burst(); after_checks("R5");
      burst(); after_checks("R5"); data_run(20);
      for (int i = 0; i < NL; i++) d[i] = 3 - (i % 4);
      burst(); after_checks("R5");
      burst(); after_checks("R5"); data_run(20);
      // R7 breaks the chain
      for (int i = 0; i < NL; i++) d[i] = (i % 2);
      burst(); after_checks("R7");
      for (int i = 0; i < NL; i++) d[i] = (i == 9) ? 5 : 1;
      burst(); after_checks("R7");
      for (int i = 0; i < NL; i++) d[i] = (i % 2);
      burst(); after_checks("R7");
      burst(); after_checks("R5"); data_run(20);

      // R8 forced phases
      for (int r = 0; r < 3; r++) begin
         logic [33:0] off_before;
         off_before = lane_offsets;
         for (int i = 0; i < NL; i++) cfg_phase[i*2 +: 2] = 2'($urandom_range(3, 0));
         cfg_force = 1; force_m = 1; data_tag = "R8";
         repeat (6) send(rnd_word());
         data_run(25);
         chk(lane_offsets == off_before, "R8", 64'(lane_offsets), 64'(off_before));
      end
      cfg_force = 0; force_m = 0; data_tag = "R4";
      repeat (6) send(rnd_word());
      data_run(20);

      // random delays, both confirmation modes
      for (int r = 0; r < 6; r++) begin
         cfg_confirm = r[0]; conf_m = r[0];
         for (int i = 0; i < NL; i++) d[i] = $urandom_range(3, 0);
         burst(); after_checks("R3");
         if (conf_m) begin burst(); after_checks("R5"); end
         data_run(20);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule